// File: doc/BRIEF.md
# Saturating Arithmetic Unit

This block is a 32-bit arithmetic unit that never wraps. It adds or subtracts two operands as signed or unsigned values. When the true result does not fit, it returns the nearest representable value. It can also clamp one word, or two independent halfwords, to a signed or unsigned range whose bit count is programmable. An opcode picks the operation, and the result is captured in a single register stage.

Every clamp sets a sticky saturation flag. This lets software run a long sequence of operations and then ask whether any of them was clipped. No operation ever lowers the flag. Only a dedicated clear input resets it. When a clear and a clamp land in the same cycle, the flag ends up set.

Top module: `sat_alu`

## Requirements
- R1: Opcode 1 (signed add) returns a+b. When a and b share a sign and the wrapped sum's sign differs from a, it instead returns 0x7FFFFFFF if a is non-negative and 0x80000000 if a is negative.
- R2: Opcode 2 (signed subtract) returns a-b. When a and b differ in sign and the wrapped difference's sign differs from a, it instead returns 0x7FFFFFFF if a is non-negative and 0x80000000 if a is negative.
- R3: Opcode 3 (unsigned add) returns a+b, or 0xFFFFFFFF when the true sum exceeds 32 bits.
- R4: Opcode 4 (unsigned subtract) returns a-b, or 0 when b is larger than a.
- R5: Opcode 5 (signed word clamp) treats a as a signed word and uses n = sat_bits_i (0..31). Values above 2^n-1 become 2^n-1, values below -2^n become -2^n, and all other values pass through unchanged.
- R6: Opcode 6 (unsigned word clamp) treats a as a signed word and uses n = sat_bits_i. Negative values become 0, values above 2^n-1 become 2^n-1, and all other values pass through.
- R7: Opcode 7 applies the signed clamp of R5 separately to a[15:0] and a[31:16], each read as a signed halfword, with n = sat_bits_i[3:0]. Each 16-bit result is packed back into its own half.
- R8: Opcode 8 applies the unsigned clamp of R6 separately to each signed halfword of a in the same way, with n = sat_bits_i[3:0].
- R9: The result of an operation appears on result_o after the rising edge that samples it. Opcodes 0 and 9..15 are idle: they leave result_o and sticky_o unchanged.
- R10: sticky_o goes high after any operation that clamps, including a clamp in either half. Operations never lower it.
- R11: sticky_clr_i lowers sticky_o at the next edge. If an operation clamps in the same cycle, sticky_o is high after that edge.
- R12: While rst_ni is low, result_o is 0 and sticky_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| op_i | input | 4 | Operation code |
| a_i | input | 32 | First operand, or the value to clamp |
| b_i | input | 32 | Second operand for add and subtract |
| sat_bits_i | input | 5 | Clamp bit count n |
| sticky_clr_i | input | 1 | Lowers the saturation flag |
| result_o | output | 32 | Registered result |
| sticky_o | output | 1 | Sticky saturation flag |

## Verification
The bench builds the unit with the default 32-bit data width, so each halfword is 16 bits. This makes every clamp width reachable: n from 0 to 31 for a word and 0 to 15 for a halfword. The extremes matter most: n = 0 keeps only -1 and 0, and n = 31 never clips a signed word. Operands are drawn often from the sign-boundary values 0x7FFFFFFF, 0x80000000, 0xFFFFFFFF and 0, so overflow in both directions and clamps in one half only are exercised repeatedly against a behavioural model.

// File: rtl/sat_alu_pkg.sv
package sat_alu_pkg;

    typedef enum logic [3:0] {
        OP_IDLE  = 4'd0,
        OP_SADD  = 4'd1,
        OP_SSUB  = 4'd2,
        OP_UADD  = 4'd3,
        OP_USUB  = 4'd4,
        OP_SCLMP = 4'd5,
        OP_UCLMP = 4'd6,
        OP_SCLP2 = 4'd7,
        OP_UCLP2 = 4'd8
    } sat_op_e;

    localparam logic [3:0] OP_LAST = 4'd8;

endpackage

// File: rtl/sat_addsub.sv
// Add/subtract with overflow detection and clamp value selection.
module sat_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    input  logic         signed_i,
    output logic [W-1:0] res_o,
    output logic         clip_o
);
    localparam int M = W - 1;

    logic [W:0]   sum_w;
    logic [W:0]   dif_w;
    logic [W-1:0] raw;
    logic         carry;
    logic         s_ovf;

    always_comb begin
        sum_w = {1'b0, a_i} + {1'b0, b_i};
        dif_w = {1'b0, a_i} - {1'b0, b_i};
        raw   = sub_i ? dif_w[W-1:0] : sum_w[W-1:0];
        carry = sub_i ? dif_w[W] : sum_w[W];
        if (sub_i) begin
            s_ovf = (a_i[M] != b_i[M]) && (raw[M] != a_i[M]);
        end else begin
            s_ovf = (a_i[M] == b_i[M]) && (raw[M] != a_i[M]);
        end

        res_o  = raw;
        clip_o = 1'b0;
        if (signed_i) begin
            if (s_ovf) begin
                res_o  = {a_i[M], {(W-1){~a_i[M]}}};
                clip_o = 1'b1;
            end
        end else if (carry) begin
            res_o  = sub_i ? '0 : '1;
            clip_o = 1'b1;
        end
    end

endmodule

// File: rtl/sat_clamp.sv
// Clamps one signed lane to an n-bit signed or unsigned range.
module sat_clamp #(
    parameter int LW = 32,
    localparam int NW = $clog2(LW)
) (
    input  logic [LW-1:0] val_i,
    input  logic [NW-1:0] n_i,
    input  logic          signed_i,
    output logic [LW-1:0] res_o,
    output logic          clip_o
);
    logic [LW-1:0] lim;
    logic          over;
    logic          under;

    always_comb begin
        lim = (LW'(1) << n_i) - LW'(1);
        if (signed_i) begin
            over  = $signed(val_i) > $signed(lim);
            under = $signed(val_i) < $signed(~lim);
        end else begin
            under = val_i[LW-1];
            over  = !val_i[LW-1] && (val_i > lim);
        end

        if (over) begin
            res_o = lim;
        end else if (under) begin
            res_o = signed_i ? ~lim : '0;
        end else begin
            res_o = val_i;
        end
        clip_o = over | under;
    end

endmodule

// File: rtl/sat_alu.sv
module sat_alu
    import sat_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic [3:0]                 op_i,
    input  logic [DATA_W-1:0]          a_i,
    input  logic [DATA_W-1:0]          b_i,
    input  logic [$clog2(DATA_W)-1:0]  sat_bits_i,
    input  logic                       sticky_clr_i,
    output logic [DATA_W-1:0]          result_o,
    output logic                       sticky_o
);
    localparam int HALF_W = DATA_W / 2;
    localparam int HNW    = $clog2(HALF_W);
    localparam int LANES  = 2;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              sticky;
    } state_t;

    state_t st_d, st_q;
    sat_op_e op;

    logic              as_sub, as_signed, as_clip;
    logic [DATA_W-1:0] as_res;
    logic              wd_signed, wd_clip;
    logic [DATA_W-1:0] wd_res;
    logic              hf_signed;
    logic [HALF_W-1:0] hf_res [LANES];
    logic [LANES-1:0]  hf_clip;

    always_comb begin
        op = (op_i > OP_LAST) ? OP_IDLE : sat_op_e'(op_i);
        as_sub    = (op == OP_SSUB) || (op == OP_USUB);
        as_signed = (op == OP_SADD) || (op == OP_SSUB);
        wd_signed = (op == OP_SCLMP);
        hf_signed = (op == OP_SCLP2);
    end

    sat_addsub #(.W(DATA_W)) u_addsub (
        .a_i      (a_i),
        .b_i      (b_i),
        .sub_i    (as_sub),
        .signed_i (as_signed),
        .res_o    (as_res),
        .clip_o   (as_clip)
    );

    sat_clamp #(.LW(DATA_W)) u_word (
        .val_i    (a_i),
        .n_i      (sat_bits_i),
        .signed_i (wd_signed),
        .res_o    (wd_res),
        .clip_o   (wd_clip)
    );

    for (genvar h = 0; h < LANES; h++) begin : g_half
        sat_clamp #(.LW(HALF_W)) u_half (
            .val_i    (a_i[h*HALF_W +: HALF_W]),
            .n_i      (sat_bits_i[HNW-1:0]),
            .signed_i (hf_signed),
            .res_o    (hf_res[h]),
            .clip_o   (hf_clip[h])
        );
    end

    always_comb begin
        logic clip;
        st_d = st_q;
        clip = 1'b0;
        unique case (op)
            OP_SADD, OP_SSUB, OP_UADD, OP_USUB: begin
                st_d.res = as_res;
                clip     = as_clip;
            end
            OP_SCLMP, OP_UCLMP: begin
                st_d.res = wd_res;
                clip     = wd_clip;
            end
            OP_SCLP2, OP_UCLP2: begin
                st_d.res = {hf_res[1], hf_res[0]};
                clip     = |hf_clip;
            end
            default: begin
                st_d.res = st_q.res;
            end
        endcase
        st_d.sticky = (st_q.sticky & ~sticky_clr_i) | clip;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result_o = st_q.res;
    assign sticky_o = st_q.sticky;

endmodule

// File: rtl/sat_alu_chk.sv
module sat_alu_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [3:0]        op_i,
    input logic [DATA_W-1:0] a_i,
    input logic [DATA_W-1:0] b_i,
    input logic              sticky_clr_i,
    input logic [DATA_W-1:0] result_o,
    input logic              sticky_o
);
    localparam int M = DATA_W - 1;

    logic [DATA_W:0] usum;
    assign usum = {1'b0, a_i} + {1'b0, b_i};

    // R10: operations never lower the flag
    p_sticky_keep_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sticky_o && !sticky_clr_i |=> sticky_o);

    // R11: clear with an idle op lowers the flag
    p_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sticky_clr_i && (op_i == 4'd0) |=> !sticky_o);

    // R11: set wins over clear
    p_set_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sticky_clr_i && (op_i == 4'd4) && (a_i < b_i) |=> sticky_o);

    // R9: idle ops hold the result
    p_idle_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == 4'd0) || (op_i > 4'd8) |=> $stable(result_o));

    // R3: unsigned add wrap gives all ones
    p_uadd_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == 4'd3) && usum[DATA_W] |=> (result_o == '1) && sticky_o);

    // R4: unsigned subtract borrow gives zero
    p_usub_floor_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == 4'd4) && (a_i < b_i) |=> (result_o == '0) && sticky_o);

    // R1: two non-negative addends never give a negative result
    p_sadd_pos_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == 4'd1) && !a_i[M] && !b_i[M] |=> !result_o[M]);

    // R2: negative minus non-negative never gives a non-negative result
    p_ssub_neg_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == 4'd2) && a_i[M] && !b_i[M] |=> result_o[M]);

endmodule

bind sat_alu sat_alu_chk #(.DATA_W(DATA_W)) chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .op_i         (op_i),
    .a_i          (a_i),
    .b_i          (b_i),
    .sticky_clr_i (sticky_clr_i),
    .result_o     (result_o),
    .sticky_o     (sticky_o)
);

// File: tb/sat_alu_tb_top.sv
module sat_alu_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op = 4'd0;
    logic [31:0] a = '0;
    logic [31:0] b = '0;
    logic [4:0]  nb = '0;
    logic        clr = 1'b0;
    logic [31:0] result;
    logic        sticky;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] exp_res = '0;
    bit          exp_st = 0;

    always #2 clk = ~clk;

    sat_alu #(.DATA_W(32)) dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .op_i         (op),
        .a_i          (a),
        .b_i          (b),
        .sat_bits_i   (nb),
        .sticky_clr_i (clr),
        .result_o     (result),
        .sticky_o     (sticky)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    function automatic longint s_clamp(input longint v, input int n, output bit c);
        longint hi = (longint'(1) << n) - 1;
        longint lo = -(longint'(1) << n);
        c = 1'b0;
        if (v > hi) begin c = 1'b1; return hi; end
        if (v < lo) begin c = 1'b1; return lo; end
        return v;
    endfunction

    function automatic longint u_clamp(input longint v, input int n, output bit c);
        longint hi = (longint'(1) << n) - 1;
        c = 1'b0;
        if (v < 0) begin c = 1'b1; return 0; end
        if (v > hi) begin c = 1'b1; return hi; end
        return v;
    endfunction

    function automatic string req_of(input int o);
        case (o)
            1: return "R1";
            2: return "R2";
            3: return "R3";
            4: return "R4";
            5: return "R5";
            6: return "R6";
            7: return "R7";
            8: return "R8";
            default: return "R9";
        endcase
    endfunction

    // Behavioural reference: updates exp_res / exp_st for one operation.
    task automatic model(input int o, input logic [31:0] av, input logic [31:0] bv,
                         input int n, input bit cl);
        longint r;
        longint sa = longint'($signed(av));
        longint sb = longint'($signed(bv));
        longint ua = longint'(av);
        longint ub = longint'(bv);
        bit c = 0, c0 = 0, c1 = 0;
        logic [15:0] h0, h1;
        case (o)
            1, 2: begin
                r = (o == 1) ? sa + sb : sa - sb;
                if (r > 64'sh7FFF_FFFF) begin r = 64'sh7FFF_FFFF; c = 1; end
                if (r < -64'sh8000_0000) begin r = -64'sh8000_0000; c = 1; end
                exp_res = r[31:0];
            end
            3: begin
                r = ua + ub;
                if (r > 64'hFFFF_FFFF) begin r = 64'hFFFF_FFFF; c = 1; end
                exp_res = r[31:0];
            end
            4: begin
                r = ua - ub;
                if (r < 0) begin r = 0; c = 1; end
                exp_res = r[31:0];
            end
            5: begin r = s_clamp(sa, n, c); exp_res = r[31:0]; end
            6: begin r = u_clamp(sa, n, c); exp_res = r[31:0]; end
            7, 8: begin
                longint v0 = longint'($signed(av[15:0]));
                longint v1 = longint'($signed(av[31:16]));
                longint q0, q1;
                if (o == 7) begin
                    q0 = s_clamp(v0, n % 16, c0);
                    q1 = s_clamp(v1, n % 16, c1);
                end else begin
                    q0 = u_clamp(v0, n % 16, c0);
                    q1 = u_clamp(v1, n % 16, c1);
                end
                h0 = q0[15:0];
                h1 = q1[15:0];
                exp_res = {h1, h0};
                c = c0 | c1;
            end
            default: ;
        endcase
        exp_st = (exp_st & !cl) | c;
    endtask

    task automatic step(input int o, input logic [31:0] av, input logic [31:0] bv,
                        input int n, input bit cl, input string req);
        op = 4'(o); a = av; b = bv; nb = 5'(n); clr = cl;
        model(o, av, bv, n, cl);
        @(posedge clk);
        #1;
        check(result === exp_res, req, "result", result, exp_res);
        check(sticky === exp_st, req, "sticky", {31'd0, sticky}, {31'd0, exp_st});
    endtask

    function automatic logic [31:0] pick();
        case ($urandom_range(0, 7))
            0: return 32'h7FFF_FFFF;
            1: return 32'h8000_0000;
            2: return 32'hFFFF_FFFF;
            3: return 32'h0000_0000;
            4: return {$urandom_range(0, 1) ? 16'h7FFF : 16'h8000, 16'($urandom)};
            default: return $urandom;
        endcase
    endfunction

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=%h expected=%h", 32'd0, 32'd1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R12: reset state
        check(result === 32'd0, "R12", "result", result, 32'd0);
        check(sticky === 1'b0, "R12", "sticky", {31'd0, sticky}, 32'd0);
        rst_n = 1'b1;

        // R1
        step(1, 32'd5, 32'd7, 0, 0, "R1");
        step(1, 32'h7FFF_FFFF, 32'd1, 0, 0, "R1");
        step(0, 32'd0, 32'd0, 0, 1, "R11");
        step(1, 32'h8000_0000, 32'hFFFF_FFFF, 0, 0, "R1");
        step(1, 32'hFFFF_FFFF, 32'h0000_0001, 0, 1, "R1");
        // R2
        step(2, 32'h8000_0000, 32'd1, 0, 0, "R2");
        step(2, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 0, 1, "R2");
        step(2, 32'd10, 32'd20, 0, 1, "R2");
        // R3, R4
        step(3, 32'hFFFF_FFF0, 32'h20, 0, 0, "R3");
        step(3, 32'd100, 32'd200, 0, 1, "R3");
        step(4, 32'd3, 32'd5, 0, 1, "R4");
        step(4, 32'd9, 32'd5, 0, 1, "R4");
        // R10: non-clipping op after a clip keeps the flag
        step(4, 32'd3, 32'd5, 0, 0, "R10");
        step(3, 32'd1, 32'd1, 0, 0, "R10");
        step(0, 0, 0, 0, 1, "R11");
        // R5
        step(5, 32'd300, 0, 7, 0, "R5");
        step(5, -32'sd300, 0, 7, 0, "R5");
        step(5, 32'd50, 0, 7, 1, "R5");
        step(5, 32'hFFFF_FFFF, 0, 0, 0, "R5");
        step(5, 32'd1, 0, 0, 0, "R5");
        step(5, 32'h8000_0000, 0, 31, 1, "R5");
        // R6
        step(6, -32'sd5, 0, 8, 1, "R6");
        step(6, 32'd1000, 0, 8, 1, "R6");
        step(6, 32'd200, 0, 8, 1, "R6");
        step(6, 32'h7FFF_FFFF, 0, 31, 1, "R6");
        // R7, R8
        step(7, 32'h7000_8000, 0, 7, 1, "R7");
        step(7, 32'h0010_7000, 0, 7, 1, "R7");
        step(7, 32'h0010_0020, 0, 23, 1, "R7");
        step(8, 32'hFFF0_0400, 0, 8, 1, "R8");
        step(8, 32'h0040_0030, 0, 6, 1, "R8");
        // R9: idle opcodes hold everything
        step(0, 32'h1234_5678, 32'h1, 3, 0, "R9");
        step(12, 32'h7FFF_FFFF, 32'h1, 3, 0, "R9");
        step(15, 32'h8000_0000, 32'h1, 0, 0, "R9");
        // R11: set wins over clear
        step(4, 32'd0, 32'd1, 0, 1, "R11");
        step(4, 32'd5, 32'd1, 0, 1, "R11");

        for (int i = 0; i < 600; i++) begin
            int o = $urandom_range(0, 15);
            step(o, pick(), pick(), $urandom_range(0, 31),
                 ($urandom_range(0, 7) == 0), req_of(o));
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule